// File: doc/BRIEF.md
# SDRAM Command Legality Monitor

This block watches the command pins of a four-bank SDRAM interface. It is passive: it drives nothing toward the memory. Each cycle it decodes the chip-select, row-strobe, column-strobe, write-enable, bank-address and A10 inputs into a command. It keeps a state machine for every bank and one for the whole device, and it reports any command that the current state does not allow. Timed transitions (row open, precharge, mode-register settle, self-refresh exit and burst length) count cycles set by parameters.

A command that is flagged as illegal is treated as a NOP. It starts no transition, but any countdown that is already running keeps going. The flag, the decoded command code, the per-bank states and the device mode are all outputs of registers. The flag and the command code therefore describe the command sampled at the previous rising edge.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: The pins {ras_n,cas_n,we_n} decode as follows when cs_n is low: 011 ACT (code 2), 101 READ (3), 100 WRITE (4), 010 PRE (5), 001 REF (6), 000 MRS (7), 110 BST (8), 111 NOP (1). cs_n high is DESEL (0), whatever the other pins are. cmd_o shows the code one cycle after the command is sampled.
- R2: illegal_o is high in the cycle after an illegal command and low after a legal one. An illegal command causes no state change, but running countdowns continue.
- R3: For an idle bank (state 0), ACT and PRE are legal, and READ, WRITE and BST are illegal. REF and MRS address all banks and are legal only when every bank is idle.
- R4: ACT moves a bank to opening (1), where it stays for T_RCD cycles before it becomes open (2). Any command addressed to an opening bank is illegal.
- R5: For an open bank, READ or WRITE starts a burst, PRE starts precharge, BST is legal with no effect, and ACT, REF and MRS are illegal.
- R6: A read burst (3) lasts BURST_CYC cycles under NOP/DESEL and then returns the bank to open. In a read burst, READ restarts the burst, PRE ends it and starts precharge, BST ends it, and ACT, WRITE, REF and MRS are illegal.
- R7: A write burst (4) lasts BURST_CYC cycles under NOP/DESEL. In a write burst, WRITE restarts the burst, PRE ends it, and READ, BST, ACT, REF and MRS are illegal.
- R8: A READ or WRITE with A10 high moves the bank to precharging when its burst ends. BST is illegal in a read burst that has A10 set.
- R9: The precharging state (5) lasts T_RP cycles and then the bank is idle. Commands addressed to it are illegal. PRE with A10 high addresses every bank.
- R10: MRS puts every bank in mode-set (6) for T_MRD cycles, then all banks return to idle. Any non-NOP command in that interval is illegal.
- R11: NOP/DESEL with cke low while all banks are idle enters power-down (dev_mode_o 1). NOP/DESEL with cke high leaves power-down. Any other command in power-down is illegal. With cke low in normal mode (0), anything other than these two entries is illegal.
- R12: REF with cke low while all banks are idle enters self-refresh (2). NOP/DESEL with cke high starts the exit phase (3), which lasts T_SREX cycles before normal mode. Non-NOP commands in self-refresh or in the exit phase, and cke low in the exit phase, are illegal.
- R13: After reset, all banks are idle, the device is in normal mode, illegal_o is low and cmd_o is DESEL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cke | input | 1 | Clock enable pin |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W | Bank address |
| a10 | input | 1 | Precharge-all / auto-precharge select |
| illegal_o | output | 1 | Previous command was illegal |
| cmd_o | output | 4 | Code of the previous command |
| bank_state_o | output | 3*NUM_BANKS | Per-bank state, bank i in bits [3i+2:3i] |
| dev_mode_o | output | 2 | Device mode: 0 normal, 1 power-down, 2 self-refresh, 3 self-refresh exit |

## Verification
Directed sequences lead each bank through every state and then issue both a legal and a forbidden command there. This separates a wrong legality entry from a wrong transition. Countdowns are probed one cycle before and at expiry, so an off-by-one in T_RCD, T_RP, T_MRD, T_SREX or the burst length shows up. Constrained-random traffic is mostly NOPs with all command types mixed in and cke dropped at times. It reaches combinations the directed part does not: PRE to an idle bank, burst restarts on the last burst cycle, and power entries attempted with busy banks. All of these are compared against a reference model in the bench on every cycle.

// File: rtl/sdram_chk_pkg.sv
package sdram_chk_pkg;

    typedef enum logic [3:0] {
        CMD_DESEL = 4'd0,
        CMD_NOP   = 4'd1,
        CMD_ACT   = 4'd2,
        CMD_RD    = 4'd3,
        CMD_WR    = 4'd4,
        CMD_PRE   = 4'd5,
        CMD_REF   = 4'd6,
        CMD_MRS   = 4'd7,
        CMD_BST   = 4'd8
    } cmd_e;

    typedef enum logic [2:0] {
        BK_IDLE    = 3'd0,
        BK_OPENING = 3'd1,
        BK_OPEN    = 3'd2,
        BK_RDBURST = 3'd3,
        BK_WRBURST = 3'd4,
        BK_CLOSING = 3'd5,
        BK_MODESET = 3'd6
    } bank_e;

    typedef enum logic [1:0] {
        DV_RUN    = 2'd0,
        DV_PDOWN  = 2'd1,
        DV_SREF   = 2'd2,
        DV_SREXIT = 2'd3
    } dev_e;

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
    import sdram_chk_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e cmd
);

    always_comb begin
        if (cs_n) begin
            cmd = CMD_DESEL;
        end else begin
            case ({ras_n, cas_n, we_n})
                3'b011:  cmd = CMD_ACT;
                3'b101:  cmd = CMD_RD;
                3'b100:  cmd = CMD_WR;
                3'b010:  cmd = CMD_PRE;
                3'b001:  cmd = CMD_REF;
                3'b000:  cmd = CMD_MRS;
                3'b110:  cmd = CMD_BST;
                default: cmd = CMD_NOP;
            endcase
        end
    end

endmodule

// File: rtl/sdram_bank_fsm.sv
module sdram_bank_fsm
    import sdram_chk_pkg::*;
#(
    parameter int T_RCD     = 3,
    parameter int T_RP      = 3,
    parameter int T_MRD     = 2,
    parameter int BURST_CYC = 2,
    parameter int CNT_W     = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  cmd_e       cmd_i,
    input  logic       tgt_i,
    input  logic       a10_i,
    input  logic       apply_i,
    output logic       bad_o,
    output logic [2:0] state_o
);

    localparam logic [CNT_W-1:0] RCD_LD = CNT_W'(T_RCD - 1);
    localparam logic [CNT_W-1:0] RP_LD  = CNT_W'(T_RP - 1);
    localparam logic [CNT_W-1:0] MRD_LD = CNT_W'(T_MRD - 1);
    localparam logic [CNT_W-1:0] BUR_LD = CNT_W'(BURST_CYC - 1);

    typedef struct packed {
        bank_e            st;
        logic [CNT_W-1:0] cnt;
        logic             ap;
    } bank_t;

    bank_t r_q, r_d;

    // legality of an addressed command in the present state
    always_comb begin
        bad_o = 1'b0;
        if (tgt_i) begin
            case (r_q.st)
                BK_IDLE:    bad_o = cmd_i inside {CMD_RD, CMD_WR, CMD_BST};
                BK_OPEN:    bad_o = cmd_i inside {CMD_ACT, CMD_REF, CMD_MRS};
                BK_RDBURST: bad_o = (cmd_i inside {CMD_ACT, CMD_REF, CMD_MRS, CMD_WR})
                                    || (cmd_i == CMD_BST && r_q.ap);
                BK_WRBURST: bad_o = cmd_i inside {CMD_ACT, CMD_REF, CMD_MRS, CMD_RD, CMD_BST};
                default:    bad_o = 1'b1;
            endcase
        end
    end

    // timed progression, then command override
    always_comb begin
        r_d = r_q;
        case (r_q.st)
            BK_OPENING: begin
                if (r_q.cnt == '0) r_d.st = BK_OPEN;
                else               r_d.cnt = r_q.cnt - 1'b1;
            end
            BK_RDBURST, BK_WRBURST: begin
                if (r_q.cnt == '0) begin
                    if (r_q.ap) begin
                        r_d.st  = BK_CLOSING;
                        r_d.cnt = RP_LD;
                    end else begin
                        r_d.st = BK_OPEN;
                    end
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            BK_CLOSING, BK_MODESET: begin
                if (r_q.cnt == '0) r_d.st = BK_IDLE;
                else               r_d.cnt = r_q.cnt - 1'b1;
            end
            default: ;
        endcase

        if (apply_i && tgt_i) begin
            case (cmd_i)
                CMD_ACT: begin
                    r_d.st  = BK_OPENING;
                    r_d.cnt = RCD_LD;
                end
                CMD_RD: begin
                    r_d.st  = BK_RDBURST;
                    r_d.cnt = BUR_LD;
                    r_d.ap  = a10_i;
                end
                CMD_WR: begin
                    r_d.st  = BK_WRBURST;
                    r_d.cnt = BUR_LD;
                    r_d.ap  = a10_i;
                end
                CMD_PRE: begin
                    if (r_q.st != BK_IDLE) begin
                        r_d.st  = BK_CLOSING;
                        r_d.cnt = RP_LD;
                    end
                end
                CMD_BST: r_d.st = BK_OPEN;
                CMD_MRS: begin
                    r_d.st  = BK_MODESET;
                    r_d.cnt = MRD_LD;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{BK_IDLE, '0, 1'b0};
        else        r_q <= r_d;
    end

    assign state_o = r_q.st;

    AST_OPENING_TO_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == BK_OPENING) |=> (r_q.st inside {BK_OPENING, BK_OPEN})); // R4
    AST_CLOSING_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == BK_CLOSING) |=> (r_q.st inside {BK_CLOSING, BK_IDLE})); // R9
    AST_MODESET_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == BK_MODESET) |=> (r_q.st inside {BK_MODESET, BK_IDLE})); // R10
    AST_IDLE_HELD_WHEN_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!apply_i && r_q.st == BK_IDLE) |=> (r_q.st == BK_IDLE)); // R2

endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
    import sdram_chk_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int T_RCD     = 3,
    parameter int T_RP      = 3,
    parameter int T_MRD     = 2,
    parameter int T_SREX    = 4,
    parameter int BURST_CYC = 2,
    localparam int BA_W     = $clog2(NUM_BANKS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cke,
    input  logic                   cs_n,
    input  logic                   ras_n,
    input  logic                   cas_n,
    input  logic                   we_n,
    input  logic [BA_W-1:0]        ba,
    input  logic                   a10,
    output logic                   illegal_o,
    output logic [3:0]             cmd_o,
    output logic [3*NUM_BANKS-1:0] bank_state_o,
    output logic [1:0]             dev_mode_o
);

    localparam int MAX_A  = (T_RCD > T_RP) ? T_RCD : T_RP;
    localparam int MAX_B  = (T_MRD > BURST_CYC) ? T_MRD : BURST_CYC;
    localparam int MAX_T  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W  = $clog2(MAX_T + 1);
    localparam int DCNT_W = $clog2(T_SREX + 1);

    typedef struct packed {
        dev_e              mode;
        logic [DCNT_W-1:0] cnt;
        logic              ill;
        cmd_e              cmd;
    } dev_t;

    dev_t t_q, t_d;

    cmd_e                 cmd;
    logic                 nopish;
    logic                 all_idle;
    logic                 dev_bad;
    logic                 apply;
    logic [NUM_BANKS-1:0] tgt;
    logic [NUM_BANKS-1:0] bad_v;
    logic [NUM_BANKS-1:0] idle_v;

    sdram_cmd_decode u_dec (
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cmd   (cmd)
    );

    assign nopish = (cmd == CMD_DESEL) || (cmd == CMD_NOP);

    // which banks the present command addresses
    always_comb begin
        for (int i = 0; i < NUM_BANKS; i++) begin
            case (cmd)
                CMD_ACT, CMD_RD, CMD_WR, CMD_BST: tgt[i] = (ba == BA_W'(i));
                CMD_PRE:                          tgt[i] = a10 || (ba == BA_W'(i));
                CMD_REF, CMD_MRS:                 tgt[i] = 1'b1;
                default:                          tgt[i] = 1'b0;
            endcase
        end
    end

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        logic [2:0] st;
        sdram_bank_fsm #(
            .T_RCD     (T_RCD),
            .T_RP      (T_RP),
            .T_MRD     (T_MRD),
            .BURST_CYC (BURST_CYC),
            .CNT_W     (CNT_W)
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .cmd_i   (cmd),
            .tgt_i   (tgt[g]),
            .a10_i   (a10),
            .apply_i (apply),
            .bad_o   (bad_v[g]),
            .state_o (st)
        );
        assign bank_state_o[3*g +: 3] = st;
        assign idle_v[g] = (st == BK_IDLE);
    end

    assign all_idle = &idle_v;
    assign apply    = (t_q.mode == DV_RUN) && cke && !dev_bad;

    always_comb begin
        t_d     = t_q;
        t_d.cmd = cmd;
        dev_bad = 1'b0;
        case (t_q.mode)
            DV_RUN: begin
                if (!cke) dev_bad = !(all_idle && (nopish || cmd == CMD_REF));
                else      dev_bad = |bad_v;
                if (!cke && !dev_bad) t_d.mode = (cmd == CMD_REF) ? DV_SREF : DV_PDOWN;
            end
            DV_PDOWN: begin
                dev_bad = !nopish;
                if (cke && nopish) t_d.mode = DV_RUN;
            end
            DV_SREF: begin
                dev_bad = !nopish;
                if (cke && nopish) begin
                    t_d.mode = DV_SREXIT;
                    t_d.cnt  = DCNT_W'(T_SREX - 1);
                end
            end
            default: begin
                dev_bad = !nopish || !cke;
                if (t_q.cnt == '0) t_d.mode = DV_RUN;
                else               t_d.cnt  = t_q.cnt - 1'b1;
            end
        endcase
        t_d.ill = dev_bad;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '{DV_RUN, '0, 1'b0, CMD_DESEL};
        else        t_q <= t_d;
    end

    assign illegal_o  = t_q.ill;
    assign cmd_o      = t_q.cmd;
    assign dev_mode_o = t_q.mode;

    AST_BUSY_CKE_LOW_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (t_q.mode == DV_RUN && !cke && !all_idle) |=> (t_q.ill && t_q.mode == DV_RUN)); // R11
    AST_SREF_EXIT_PATH: assert property (@(posedge clk) disable iff (!rst_n)
        (t_q.mode == DV_SREF) |=> (t_q.mode inside {DV_SREF, DV_SREXIT})); // R12
    AST_NOP_NEVER_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (t_q.mode == DV_RUN && cke && nopish) |=> !t_q.ill); // R2
    AST_PDOWN_LEAVES_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (t_q.mode == DV_PDOWN) |=> (t_q.mode inside {DV_PDOWN, DV_RUN})); // R11

endmodule

// File: tb/tb_sdram_cmd_monitor.sv
module tb_sdram_cmd_monitor;

    localparam int CLK_PERIOD = 10;
    localparam int NB   = 4;
    localparam int RCD  = 3;
    localparam int RP   = 3;
    localparam int MRD  = 2;
    localparam int SREX = 4;
    localparam int BL   = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0] ba = 2'd0;
    logic a10 = 1'b0;
    logic illegal;
    logic [3:0] cmd_out;
    logic [3*NB-1:0] bst;
    logic [1:0] dmode;

    int checks = 0;
    int errors = 0;
    int m_st[NB];
    int m_cnt[NB];
    bit m_ap[NB];
    int m_dev = 0;
    int m_dcnt = 0;
    bit m_ill = 0;
    int m_cmd = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdram_cmd_monitor #(
        .NUM_BANKS(NB), .T_RCD(RCD), .T_RP(RP), .T_MRD(MRD),
        .T_SREX(SREX), .BURST_CYC(BL)
    ) dut (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .ba(ba), .a10(a10),
        .illegal_o(illegal), .cmd_o(cmd_out), .bank_state_o(bst), .dev_mode_o(dmode)
    );

    task automatic chk(string tag, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    function automatic bit ok_in(int s, int c, bit ap);
        case (s)
            0:       return c inside {2, 5, 6, 7};
            2:       return c inside {3, 4, 5, 8};
            3:       return (c inside {3, 5}) || (c == 8 && !ap);
            4:       return c inside {4, 5};
            default: return 1'b0;
        endcase
    endfunction

    task automatic model(bit ck, int c, int b, bit a);
        bit nop = (c <= 1);
        bit bad = 0;
        bit idle = 1;
        bit tg[NB];
        int nd;
        for (int i = 0; i < NB; i++) begin
            idle &= (m_st[i] == 0);
            if (c inside {2, 3, 4, 8}) tg[i] = (i == b);
            else if (c == 5)           tg[i] = a || (i == b);
            else                       tg[i] = (c == 6 || c == 7);
        end
        case (m_dev)
            0: begin
                if (!ck) bad = !(idle && (nop || c == 6));
                else for (int i = 0; i < NB; i++) if (tg[i] && !ok_in(m_st[i], c, m_ap[i])) bad = 1;
            end
            1, 2: bad = !nop;
            default: bad = !nop || !ck;
        endcase
        for (int i = 0; i < NB; i++) begin
            int s = m_st[i];
            int n = m_cnt[i];
            case (m_st[i])
                1: if (n == 0) s = 2; else n--;
                3, 4: if (n == 0) begin
                          if (m_ap[i]) begin s = 5; n = RP - 1; end else s = 2;
                      end else n--;
                5, 6: if (n == 0) s = 0; else n--;
                default: ;
            endcase
            if (!bad && m_dev == 0 && ck && tg[i]) begin
                case (c)
                    2: begin s = 1; n = RCD - 1; end
                    3: begin s = 3; n = BL - 1; m_ap[i] = a; end
                    4: begin s = 4; n = BL - 1; m_ap[i] = a; end
                    5: if (m_st[i] != 0) begin s = 5; n = RP - 1; end
                    7: begin s = 6; n = MRD - 1; end
                    8: s = 2;
                    default: ;
                endcase
            end
            m_st[i] = s;
            m_cnt[i] = n;
        end
        nd = m_dev;
        case (m_dev)
            0: if (!ck && !bad) nd = (c == 6) ? 2 : 1;
            1: if (ck && nop) nd = 0;
            2: if (ck && nop) begin nd = 3; m_dcnt = SREX - 1; end
            default: if (m_dcnt == 0) nd = 0; else m_dcnt--;
        endcase
        m_dev = nd;
        m_ill = bad;
        m_cmd = c;
    endtask

    task automatic issue(bit ck, int c, int b, bit a);
        @(negedge clk);
        cke = ck;
        ba = 2'(b);
        a10 = a;
        if (c == 0) begin
            cs_n = 1'b1;
            {ras_n, cas_n, we_n} = 3'($urandom);
        end else begin
            cs_n = 1'b0;
            case (c)
                2: {ras_n, cas_n, we_n} = 3'b011;
                3: {ras_n, cas_n, we_n} = 3'b101;
                4: {ras_n, cas_n, we_n} = 3'b100;
                5: {ras_n, cas_n, we_n} = 3'b010;
                6: {ras_n, cas_n, we_n} = 3'b001;
                7: {ras_n, cas_n, we_n} = 3'b000;
                8: {ras_n, cas_n, we_n} = 3'b110;
                default: {ras_n, cas_n, we_n} = 3'b111;
            endcase
        end
        model(ck, c, b, a);
        @(posedge clk);
        #1;
        chk("R2 model illegal flag", illegal, m_ill);
        chk("R1 model command code", cmd_out, m_cmd);
        chk("R11 model device mode", dmode, m_dev);
        for (int i = 0; i < NB; i++) chk("R3 model bank state", bst[i*3 +: 3], m_st[i]);
    endtask

    task automatic nops(int k);
        for (int i = 0; i < k; i++) issue(1, 1, 0, 0);
    endtask

    function automatic int bk(int i);
        return int'(bst[i*3 +: 3]);
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < NB; i++) begin m_st[i] = 0; m_cnt[i] = 0; m_ap[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R13 reset illegal", illegal, 0);
        chk("R13 reset cmd", cmd_out, 0);
        chk("R13 reset banks", int'(bst), 0);
        chk("R13 reset mode", dmode, 0);

        issue(1, 3, 0, 0); chk("R3 read on idle", illegal, 1); chk("R3 idle kept", bk(0), 0);
        issue(1, 2, 0, 0); chk("R4 act opens", bk(0), 1);
        issue(1, 4, 0, 0); chk("R4 write while opening", illegal, 1);
        issue(1, 1, 0, 0); chk("R4 still opening", bk(0), 1);
        issue(1, 1, 0, 0); chk("R4 open after tRCD", bk(0), 2);
        issue(1, 2, 0, 0); chk("R5 act on open", illegal, 1);
        issue(1, 3, 0, 0); chk("R5 read starts burst", bk(0), 3);
        issue(1, 1, 0, 0); chk("R6 burst continues", bk(0), 3);
        issue(1, 1, 0, 0); chk("R6 burst end to open", bk(0), 2);
        issue(1, 3, 0, 0);
        issue(1, 2, 0, 0); chk("R6 act in read burst", illegal, 1);
        issue(1, 5, 0, 0); chk("R6 pre terminates", bk(0), 5); chk("R1 pre code", cmd_out, 5);
        issue(1, 2, 0, 0); chk("R9 act while precharging", illegal, 1);
        issue(1, 1, 0, 0); chk("R9 still precharging", bk(0), 5);
        issue(1, 1, 0, 0); chk("R9 idle after tRP", bk(0), 0);
        issue(1, 7, 0, 0); chk("R10 mode set all", int'(bst), 12'o6666);
        issue(1, 2, 1, 0); chk("R10 act in mode set", illegal, 1);
        issue(1, 1, 0, 0); chk("R10 idle after tMRD", int'(bst), 0);
        issue(1, 2, 1, 0); nops(3); chk("R5 bank1 open", bk(1), 2);
        issue(1, 4, 1, 1); chk("R7 write burst", bk(1), 4);
        issue(1, 3, 1, 0); chk("R7 read in write burst", illegal, 1);
        issue(1, 1, 0, 0); chk("R8 autoprecharge after write", bk(1), 5);
        nops(3); chk("R8 idle after autoprecharge", bk(1), 0);
        issue(1, 2, 2, 0); nops(3);
        issue(1, 3, 2, 1);
        issue(1, 8, 2, 0); chk("R8 bst on autoprecharge read", illegal, 1);
        issue(1, 1, 0, 0); chk("R8 read autoprecharge", bk(2), 5);
        issue(1, 6, 0, 0); chk("R3 refresh with busy bank", illegal, 1);
        nops(2); chk("R9 bank2 idle", bk(2), 0);
        issue(1, 2, 3, 0); nops(3);
        issue(1, 5, 0, 1); chk("R9 precharge all", bk(3), 5); chk("R9 idle bank untouched", bk(0), 0);
        nops(3);
        issue(0, 1, 0, 0); chk("R11 power-down entry", dmode, 1);
        issue(0, 2, 0, 0); chk("R11 act in power-down", illegal, 1);
        issue(1, 1, 0, 0); chk("R11 power-down exit", dmode, 0);
        issue(1, 2, 0, 0);
        issue(0, 1, 0, 0); chk("R11 cke low with busy bank", illegal, 1); chk("R11 stays normal", dmode, 0);
        nops(3); issue(1, 5, 0, 0); nops(3);
        issue(0, 6, 0, 0); chk("R12 self-refresh entry", dmode, 2); chk("R12 entry legal", illegal, 0);
        issue(0, 1, 0, 0); chk("R12 self-refresh held", dmode, 2);
        issue(1, 1, 0, 0); chk("R12 exit phase", dmode, 3);
        issue(1, 3, 0, 0); chk("R12 read during exit", illegal, 1);
        nops(2); chk("R12 still exiting", dmode, 3);
        issue(1, 1, 0, 0); chk("R12 normal after tSREX", dmode, 0);

        for (int n = 0; n < 4000; n++) begin
            int r = $urandom_range(0, 99);
            int c = (r < 45) ? 1 : (r < 55) ? 0 : $urandom_range(2, 8);
            bit ck = ($urandom_range(0, 24) != 0);
            issue(ck, c, $urandom_range(0, NB - 1), 1'($urandom));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule